// File: doc/BRIEF.md
# Input Gate Bank with Frozen Hold

A bank of input pin gates that lets a chip stop unwanted switching on chosen inputs from spreading into its internal routing. One shared active-low blocking rail is driven by any internal logic: a direct pin, a counter bit or a state machine output. A per-pin participation mask picks which pins obey the rail. While the rail is low, every participating pin shows a frozen level to the logic behind it instead of its live, possibly toggling, value. The rail is also driven out on an observation output.

The hold element is one register bit per pin, clocked by the same clock that produces the rail. The register loads the live pin on every rising edge while the pin is open. When the pin is blocked, the register keeps its contents, and the output mux selects the register in place of the pin. A build-time parameter turns gating off for the whole bank. In that build every pin passes straight through, and the observation output carries an ordinary signal.

Top module: `ingate_bank`

## Requirements
- R1: While `rail_n_i` is 1, `pins_o` equals `pins_i` on every bit, with no clock delay.
- R2: A pin whose `part_mask_i` bit is 0 always passes `pins_i` to `pins_o`, whatever the rail value.
- R3: While `rail_n_i` is 0, a pin whose mask bit is 1 shows the value its input had at the last rising clock edge at which that pin was not blocked. Changes on its input are ignored until it is unblocked.
- R4: When `rail_n_i` returns to 1, participating pins show their live input again at once, in the same cycle.
- R5: A pin whose mask bit goes from 0 to 1 while the rail is 0 freezes at its input value from the last rising edge before it joined.
- R6: Reset (`rst_ni` = 0) clears every hold bit to 0. A participating pin that is blocked before any unblocked edge after reset reads 0.
- R7: With `GATE_USED` = 1, `obs_o` equals `rail_n_i`.
- R8: With `GATE_USED` = 0, `pins_o` equals `pins_i` for all mask and rail values, and `obs_o` equals `gp_obs_i`.
- R9: Each pin is gated by its own mask bit. Blocked and open pins mix freely in one cycle, with no effect between bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock of the hold registers and of the logic driving the rail |
| rst_ni | input | 1 | Active-low reset; clears the hold registers |
| pins_i | input | N | Live pin levels |
| part_mask_i | input | N | Participation select; 1 = the pin obeys the rail |
| rail_n_i | input | 1 | Blocking rail; 0 = block participating pins |
| gp_obs_i | input | 1 | Ordinary signal driven out on `obs_o` when gating is built out |
| pins_o | output | N | Levels delivered to the internal routing |
| obs_o | output | 1 | Observation output (rail, or `gp_obs_i`) |

## Verification
The bench builds two instances. The first uses N = 8 with gating on. Its mask patterns split the bank into nibbles, so blocked and open pins, pins joining mid-block and rail recovery all occur in one sweep. The second uses N = 4 with gating off. It shows that the same rail and mask stimulus then has no effect, and that the observation output follows the ordinary signal.

// File: rtl/ingate_pkg.sv
`timescale 1ns/1ps
package ingate_pkg;

    // Level of the blocking rail that closes participating pins.
    localparam logic RAIL_BLOCK = 1'b0;

    // Builds of the bank.
    typedef enum logic {
        BUILD_PASS  = 1'b0,
        BUILD_GATED = 1'b1
    } build_e;

endpackage

// File: rtl/ingate_hold_reg.sv
`timescale 1ns/1ps
module ingate_hold_reg #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pins_i,
    input  logic [N-1:0] load_i,
    output logic [N-1:0] hold_o
);

    typedef struct packed {
        logic [N-1:0] hold;
    } hold_st_t;

    hold_st_t st_d;
    hold_st_t st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < N; b++) begin
            if (load_i[b]) begin
                st_d.hold[b] = pins_i[b];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.hold;

endmodule

// File: rtl/ingate_obs_sel.sv
`timescale 1ns/1ps
module ingate_obs_sel
    import ingate_pkg::*;
#(
    parameter build_e BUILD = BUILD_GATED
) (
    input  logic rail_n_i,
    input  logic gp_obs_i,
    output logic obs_o
);

    always_comb begin
        obs_o = (BUILD == BUILD_GATED) ? rail_n_i : gp_obs_i;
    end

endmodule

// File: rtl/ingate_bank.sv
`timescale 1ns/1ps
module ingate_bank
    import ingate_pkg::*;
#(
    parameter int N         = 8,
    parameter bit GATE_USED = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pins_i,
    input  logic [N-1:0] part_mask_i,
    input  logic         rail_n_i,
    input  logic         gp_obs_i,
    output logic [N-1:0] pins_o,
    output logic         obs_o
);

    localparam build_e BUILD = GATE_USED ? BUILD_GATED : BUILD_PASS;

    logic [N-1:0] blocked;
    logic [N-1:0] load;
    logic [N-1:0] hold;

    // A pin is closed only in the gated build, when selected and the rail blocks.
    always_comb begin
        if (BUILD == BUILD_GATED) begin
            blocked = part_mask_i & {N{rail_n_i == RAIL_BLOCK}};
        end else begin
            blocked = '0;
        end
        load = ~blocked;
    end

    ingate_hold_reg #(
        .N (N)
    ) hold_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pins_i (pins_i),
        .load_i (load),
        .hold_o (hold)
    );

    for (genvar g = 0; g < N; g++) begin : g_pin
        always_comb begin
            pins_o[g] = blocked[g] ? hold[g] : pins_i[g];
        end
    end

    ingate_obs_sel #(
        .BUILD (BUILD)
    ) obs_i (
        .rail_n_i (rail_n_i),
        .gp_obs_i (gp_obs_i),
        .obs_o    (obs_o)
    );

endmodule

// File: rtl/ingate_bank_chk.sv
`timescale 1ns/1ps
module ingate_bank_chk #(
    parameter int N         = 8,
    parameter bit GATE_USED = 1'b1
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [N-1:0] pins_i,
    input logic [N-1:0] part_mask_i,
    input logic         rail_n_i,
    input logic         gp_obs_i,
    input logic [N-1:0] pins_o,
    input logic         obs_o
);

    AST_OPEN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rail_n_i |-> (pins_o == pins_i)); // R1

    AST_UNMASKED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pins_o & ~part_mask_i) == (pins_i & ~part_mask_i))); // R2

    AST_RESUME_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rail_n_i) |-> (pins_o == pins_i)); // R4

    if (GATE_USED) begin : g_gated
        AST_BLOCKED_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!rail_n_i && !$past(rail_n_i)) |->
            (((pins_o ^ $past(pins_o)) & part_mask_i & $past(part_mask_i)) == '0)); // R3

        AST_OBS_RAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (obs_o == rail_n_i)); // R7
    end else begin : g_pass
        AST_NO_GATE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((pins_o == pins_i) && (obs_o == gp_obs_i))); // R8
    end

endmodule

bind ingate_bank ingate_bank_chk #(
    .N         (N),
    .GATE_USED (GATE_USED)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pins_i      (pins_i),
    .part_mask_i (part_mask_i),
    .rail_n_i    (rail_n_i),
    .gp_obs_i    (gp_obs_i),
    .pins_o      (pins_o),
    .obs_o       (obs_o)
);

// File: tb/ingate_bank_tb_top.sv
`timescale 1ns/1ps
module ingate_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'h00;
    logic [7:0] mask = 8'hFF;
    logic       rail_n = 1'b1;
    logic       gp = 1'b0;
    logic [7:0] pins_out;
    logic       obs;

    logic [3:0] np_pins = 4'h0;
    logic [3:0] np_mask = 4'hF;
    logic       np_rail = 1'b1;
    logic       np_gp = 1'b0;
    logic [3:0] np_out;
    logic       np_obs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ingate_bank #(.N(8), .GATE_USED(1'b1)) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .pins_i (pins), .part_mask_i (mask),
        .rail_n_i (rail_n), .gp_obs_i (gp), .pins_o (pins_out), .obs_o (obs)
    );

    ingate_bank #(.N(4), .GATE_USED(1'b0)) dut_nogate_i (
        .clk_i (clk), .rst_ni (rst_n), .pins_i (np_pins), .part_mask_i (np_mask),
        .rail_n_i (np_rail), .gp_obs_i (np_gp), .pins_o (np_out), .obs_o (np_obs)
    );

    // {rail, mask, pins, expected pins_o, tag}; applied one per cycle in order.
    localparam logic [28:0] VEC [0:9] = '{
        {1'b1, 8'hFF, 8'hA5, 8'hA5, 4'd1}, // R1 open
        {1'b1, 8'hFF, 8'h3C, 8'h3C, 4'd1}, // R1 open
        {1'b0, 8'hFF, 8'hC3, 8'h3C, 4'd3}, // R3 block, keep 3C
        {1'b0, 8'hFF, 8'h00, 8'h3C, 4'd3}, // R3 input ignored
        {1'b0, 8'h0F, 8'h5A, 8'h5C, 4'd9}, // R9 high nibble live
        {1'b0, 8'hFF, 8'h99, 8'h5C, 4'd5}, // R5 high nibble joins at 5
        {1'b1, 8'hFF, 8'h77, 8'h77, 4'd4}, // R4 live at once
        {1'b0, 8'hF0, 8'h11, 8'h71, 4'd9}, // R9 mixed
        {1'b0, 8'h00, 8'hE8, 8'hE8, 4'd2}, // R2 no participants
        {1'b1, 8'h00, 8'h42, 8'h42, 4'd2}  // R2 open, unmasked
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R6: blocked during reset with no open edge reads 0.
        @(negedge clk);
        pins = 8'hFF; mask = 8'hFF; rail_n = 1'b0;
        #1 chk("R6 in reset", pins_out, 8'h00);
        chk("R7 obs in reset", {7'd0, obs}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk("R6 after reset, still blocked", pins_out, 8'h00);
        @(negedge clk);
        rail_n = 1'b1;
        #1 chk("R4 release after reset", pins_out, 8'hFF);

        // Table sweep.
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            rail_n = VEC[k][28];
            mask   = VEC[k][27:20];
            pins   = VEC[k][19:12];
            #1;
            chk($sformatf("R%0d vector %0d", VEC[k][3:0], k), pins_out, VEC[k][11:4]);
            chk($sformatf("R7 obs vector %0d", k), {7'd0, obs}, {7'd0, VEC[k][28]});
        end

        // R3: toggling a blocked pin over several edges does not reach the output.
        @(negedge clk);
        rail_n = 1'b1; mask = 8'h01; pins = 8'h01;
        @(negedge clk);
        rail_n = 1'b0;
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            pins = {7'd0, t[0]};
            #1 chk("R3 toggle held", pins_out, 8'h01);
        end

        // R8: gating built out.
        @(negedge clk);
        np_rail = 1'b0; np_mask = 4'hF; np_pins = 4'hA; np_gp = 1'b1;
        #1 chk("R8 pass with rail low", {4'd0, np_out}, 8'h0A);
        chk("R8 obs follows gp", {7'd0, np_obs}, 8'h01);
        @(negedge clk);
        np_pins = 4'h5; np_gp = 1'b0;
        #1 chk("R8 pass after edge", {4'd0, np_out}, 8'h05);
        chk("R8 obs follows gp low", {7'd0, np_obs}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule